// File: doc/BRIEF.md
# Move and Logic Instruction Executor

This block executes one instruction per cycle from a small slice of a 32-bit RISC instruction set whose instructions are one, two or three 16-bit halfwords long. It covers register copies, 5-bit, 16-bit and 32-bit immediate moves, add-immediate moves (low or high half), bitwise NOT, register OR and OR with an immediate. The block holds its own 32-entry, 32-bit register file. Register 0 reads as zero and ignores writes.

An outer fetch stage presents the first halfword and the two halfwords after it, all at once, with a valid strobe. One cycle later the block reports the destination index, the result, a write-enable, the four condition flags and the instruction length in halfwords, so the fetch stage can advance. The register file and the flags update on the same clock edge, so the next instruction, even one issued back to back, sees the new values.

Top module: `movlogic_exec`

## Requirements
- R1: After reset `out_valid` and `wr_en` are low and all four flags (`flag_cy`, `flag_ov`, `flag_s`, `flag_z`) are 0.
- R2: The first halfword is split into the second register / destination in bits 15:11, the opcode in bits 10:5 and the first register or a 5-bit immediate in bits 4:0. Opcode 000000 copies the first register to the second, with length 1.
- R3: Opcode 000001 writes the bitwise NOT of the first register to the second. Opcode 001000 writes the second register OR the first register to the second. Both have length 1.
- R4: Opcode 010000 writes the 5-bit immediate, sign-extended to 32 bits, to the second register, with length 1.
- R5: Opcode 110001 with a nonzero second-register field writes the first register plus the sign-extended second halfword, with length 2. When the second-register field is 0 it writes to the first register the 32-bit value made of the second halfword (low half) and the third halfword (high half), with length 3.
- R6: Opcode 110010 writes the first register plus the second halfword shifted into bits 31:16 (low 16 bits zero), with length 2.
- R7: Opcode 110100 writes the first register OR the zero-extended second halfword, with length 2.
- R8: A result whose destination is register 0 has `wr_en` low and changes nothing, and register 0 always reads as zero.
- R9: NOT, OR and OR-immediate clear `flag_ov`, copy result bit 31 to `flag_s`, set `flag_z` when the result is zero, and leave `flag_cy` unchanged.
- R10: All move forms (opcodes 000000, 010000, 110001, 110010) leave all four flags unchanged.
- R11: An all-zero first halfword is a no-operation: length 1, `wr_en` low, flags unchanged.
- R12: Any other opcode gives `wr_en` low, length 1, result 0 and unchanged flags.
- R13: `out_valid` is high exactly one cycle after each cycle with `in_valid` high, and `wr_en` is never high without `out_valid`. A result is visible to an instruction issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| hw0 | input | 16 | First instruction halfword |
| hw1 | input | 16 | Second halfword (immediate, or low half of a 32-bit immediate) |
| hw2 | input | 16 | Third halfword (high half of a 32-bit immediate) |
| out_valid | output | 1 | Result of the previous cycle's instruction |
| wr_en | output | 1 | Register file was written |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Result value |
| len | output | 2 | Instruction length in halfwords (1 to 3) |
| flag_cy | output | 1 | Carry flag |
| flag_ov | output | 1 | Overflow flag |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |

## Verification
Registers are loaded through the three-halfword form with values whose top bit and low bit are both set. This shows whether the halves are swapped, and later reads through register copies tell sign extension apart from zero extension. The 5-bit immediates are given both negative and positive, and the add-immediate forms use an all-ones immediate and a mid-range high half, which separates the low-half add from the high-half add. The logic operations are chosen to yield a negative result, a positive nonzero result and an all-zero result, so each flag is driven both ways, while the move forms issued in between must keep the flags. Writes to register 0, the no-operation, an unknown opcode, an idle cycle and a dependent back-to-back pair cover the edges of the write path.

// File: rtl/mle_pkg.sv
package mle_pkg;

   localparam int HALF_W  = 16;
   localparam int WORD_W  = 32;
   localparam int RIDX_W  = 5;

   // opcode values taken from bits 10:5 of the first halfword
   localparam logic [5:0] OPC_COPY   = 6'b000000;
   localparam logic [5:0] OPC_INV    = 6'b000001;
   localparam logic [5:0] OPC_ORR    = 6'b001000;
   localparam logic [5:0] OPC_IMM5   = 6'b010000;
   localparam logic [5:0] OPC_ADDLO  = 6'b110001;
   localparam logic [5:0] OPC_ADDHI  = 6'b110010;
   localparam logic [5:0] OPC_ORIMM  = 6'b110100;

   typedef enum logic [2:0] {
      ALU_PASS_A,
      ALU_NOT_A,
      ALU_OR_AB,
      ALU_PASS_IMM,
      ALU_ADD_IMM,
      ALU_OR_IMM,
      ALU_ZERO
   } alu_op_e;

   typedef struct packed {
      alu_op_e             op;
      logic [RIDX_W-1:0]   src_a;
      logic [RIDX_W-1:0]   src_b;
      logic [RIDX_W-1:0]   dst;
      logic [WORD_W-1:0]   imm;
      logic [1:0]          len;
      logic                writes;
      logic                sets_flags;
   } decoded_t;

endpackage

// File: rtl/mle_decode.sv
module mle_decode
   import mle_pkg::*;
#(
   parameter int HW_W   = 16,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic [HW_W-1:0] hw0,
   input  logic [HW_W-1:0] hw1,
   input  logic [HW_W-1:0] hw2,
   output decoded_t        dec
);

   localparam int OPC_W = HW_W - 2 * IDX_W;
   localparam int EXT5  = DATA_W - IDX_W;
   localparam int EXT16 = DATA_W - HW_W;

   generate
      if (DATA_W != 2 * HW_W) begin : g_bad_width
         $error("mle_decode: DATA_W must be twice HW_W");
      end
      if (OPC_W != 6) begin : g_bad_opc
         $error("mle_decode: opcode field must be 6 bits");
      end
      if (IDX_W != RIDX_W || DATA_W != WORD_W) begin : g_bad_pkg
         $error("mle_decode: widths disagree with mle_pkg");
      end
   endgenerate

   logic [IDX_W-1:0] fld_hi;
   logic [OPC_W-1:0] fld_opc;
   logic [IDX_W-1:0] fld_lo;

   assign fld_hi  = hw0[HW_W-1 -: IDX_W];
   assign fld_opc = hw0[IDX_W +: OPC_W];
   assign fld_lo  = hw0[IDX_W-1:0];

   always_comb begin
      dec            = '0;
      dec.op         = ALU_ZERO;
      dec.src_a      = fld_lo;
      dec.src_b      = fld_hi;
      dec.dst        = fld_hi;
      dec.imm        = '0;
      dec.len        = 2'd1;
      dec.writes     = 1'b0;
      dec.sets_flags = 1'b0;
      unique case (fld_opc)
         OPC_COPY: begin
            dec.op     = ALU_PASS_A;
            dec.writes = 1'b1;
         end
         OPC_INV: begin
            dec.op         = ALU_NOT_A;
            dec.writes     = 1'b1;
            dec.sets_flags = 1'b1;
         end
         OPC_ORR: begin
            dec.op         = ALU_OR_AB;
            dec.writes     = 1'b1;
            dec.sets_flags = 1'b1;
         end
         OPC_IMM5: begin
            dec.op     = ALU_PASS_IMM;
            dec.imm    = {{EXT5{fld_lo[IDX_W-1]}}, fld_lo};
            dec.writes = 1'b1;
         end
         OPC_ADDLO: begin
            dec.writes = 1'b1;
            if (fld_hi == '0) begin
               // long form: low halfword first, destination in low field
               dec.op  = ALU_PASS_IMM;
               dec.imm = {hw2, hw1};
               dec.dst = fld_lo;
               dec.len = 2'd3;
            end else begin
               dec.op  = ALU_ADD_IMM;
               dec.imm = {{EXT16{hw1[HW_W-1]}}, hw1};
               dec.len = 2'd2;
            end
         end
         OPC_ADDHI: begin
            dec.op     = ALU_ADD_IMM;
            dec.imm    = {hw1, {HW_W{1'b0}}};
            dec.len    = 2'd2;
            dec.writes = 1'b1;
         end
         OPC_ORIMM: begin
            dec.op         = ALU_OR_IMM;
            dec.imm        = {{EXT16{1'b0}}, hw1};
            dec.len        = 2'd2;
            dec.writes     = 1'b1;
            dec.sets_flags = 1'b1;
         end
         default: begin
            dec.op = ALU_ZERO;
         end
      endcase
   end

endmodule

// File: rtl/mle_regfile.sv
module mle_regfile #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra_idx,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] rb_data
);

   localparam int NREG = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 6) begin : g_bad_idx
         $error("mle_regfile: IDX_W out of range");
      end
   endgenerate

   logic [NREG*DATA_W-1:0] flat;

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_reg
         if (g == 0) begin : g_zero
            assign flat[0 +: DATA_W] = '0;
         end else begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  q <= '0;
               end else if (we && widx == IDX_W'(g)) begin
                  q <= wdata;
               end
            end
            assign flat[g*DATA_W +: DATA_W] = q;
         end
      end
   endgenerate

   assign ra_data = flat[ra_idx*DATA_W +: DATA_W];
   assign rb_data = flat[rb_idx*DATA_W +: DATA_W];

   // R8: a write to a nonzero index is visible on the next cycle
   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx != '0 && ra_idx == widx) |=> (ra_data == $past(wdata) || $past(ra_idx) != ra_idx))
      else $error("a_r8_write_lands");

endmodule

// File: rtl/mle_alu.sv
module mle_alu
   import mle_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] result,
   output logic              res_zero,
   output logic              res_sign
);

   always_comb begin
      unique case (op)
         ALU_PASS_A:   result = opa;
         ALU_NOT_A:    result = ~opa;
         ALU_OR_AB:    result = opb | opa;
         ALU_PASS_IMM: result = imm;
         ALU_ADD_IMM:  result = opa + imm;
         ALU_OR_IMM:   result = opa | imm;
         default:      result = '0;
      endcase
   end

   assign res_zero = (result == '0);
   assign res_sign = result[DATA_W-1];

endmodule

// File: rtl/movlogic_exec.sv
module movlogic_exec
   import mle_pkg::*;
#(
   parameter int HW_W   = 16,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [HW_W-1:0]   hw0,
   input  logic [HW_W-1:0]   hw1,
   input  logic [HW_W-1:0]   hw2,
   output logic              out_valid,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic [1:0]        len,
   output logic              flag_cy,
   output logic              flag_ov,
   output logic              flag_s,
   output logic              flag_z
);

   decoded_t          dec;
   logic [DATA_W-1:0] rd_a;
   logic [DATA_W-1:0] rd_b;
   logic [DATA_W-1:0] alu_res;
   logic              alu_zero;
   logic              alu_sign;
   logic              rf_we;
   logic              logic_q;

   mle_decode #(.HW_W(HW_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
      .hw0 (hw0),
      .hw1 (hw1),
      .hw2 (hw2),
      .dec (dec)
   );

   mle_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .widx    (dec.dst),
      .wdata   (alu_res),
      .ra_idx  (dec.src_a),
      .ra_data (rd_a),
      .rb_idx  (dec.src_b),
      .rb_data (rd_b)
   );

   mle_alu #(.DATA_W(DATA_W)) u_alu (
      .op       (dec.op),
      .opa      (rd_a),
      .opb      (rd_b),
      .imm      (dec.imm),
      .result   (alu_res),
      .res_zero (alu_zero),
      .res_sign (alu_sign)
   );

   assign rf_we = in_valid && dec.writes && (dec.dst != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
         len       <= 2'd0;
         logic_q   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= rf_we;
         logic_q   <= in_valid && dec.sets_flags;
         if (in_valid) begin
            wr_idx  <= dec.dst;
            wr_data <= alu_res;
            len     <= dec.len;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_cy <= 1'b0;
         flag_ov <= 1'b0;
         flag_s  <= 1'b0;
         flag_z  <= 1'b0;
      end else if (in_valid && dec.sets_flags) begin
         flag_ov <= 1'b0;
         flag_s  <= alu_sign;
         flag_z  <= alu_zero;
      end
   end

   // R13: a result follows every accepted instruction
   a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid)
      else $error("a_r13_valid_follows");

   // R13: no write is reported without a result
   a_r13_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> out_valid)
      else $error("a_r13_we_needs_valid");

   // R8: register 0 is never reported as written
   a_r8_no_r0_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx != '0))
      else $error("a_r8_no_r0_write");

   // R9: logic results clear overflow and mirror the result in zero and sign
   a_r9_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
      logic_q |-> (!flag_ov && flag_z == (wr_data == '0) && flag_s == wr_data[DATA_W-1]))
      else $error("a_r9_logic_flags");

   // R10: moves keep every flag
   a_r10_move_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dec.sets_flags) |=> $stable({flag_cy, flag_ov, flag_s, flag_z}))
      else $error("a_r10_move_keeps_flags");

   // R9: carry is never touched by this block
   a_r9_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> $stable(flag_cy))
      else $error("a_r9_carry_kept");

   // R5: a reported result always carries a legal length
   a_r5_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (len != 2'd0))
      else $error("a_r5_len_legal");

endmodule

// File: tb/movlogic_exec_test.sv
module movlogic_exec_test;

   localparam int CLK_PERIOD = 10;

   logic        clk;
   logic        rst_n;
   logic        in_valid;
   logic [15:0] hw0, hw1, hw2;
   logic        out_valid, wr_en;
   logic [4:0]  wr_idx;
   logic [31:0] wr_data;
   logic [1:0]  len;
   logic        flag_cy, flag_ov, flag_s, flag_z;

   movlogic_exec uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .hw0(hw0), .hw1(hw1), .hw2(hw2),
      .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .len(len),
      .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_s(flag_s), .flag_z(flag_z)
   );

   typedef struct {
      logic        we;
      logic [4:0]  idx;
      logic [31:0] data;
      logic [1:0]  ln;
      logic [3:0]  flags;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad   = 0;
   bit   done  = 0;

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] enc(input logic [4:0] r2, input logic [5:0] op,
                                       input logic [4:0] r1);
      return {r2, op, r1};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic issue(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                        input logic we, input logic [4:0] idx, input logic [31:0] data,
                        input logic [1:0] ln, input logic [3:0] flags, input string req);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      hw0 = a; hw1 = b; hw2 = c;
      e.we = we; e.idx = idx; e.data = data; e.ln = ln; e.flags = flags; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      hw0 = '0; hw1 = '0; hw2 = '0;
   endtask

   // monitor: compare each produced result with the queued expectation
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check("R13", "unexpected out_valid", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(e.req, "wr_en", {31'd0, wr_en}, {31'd0, e.we});
               check(e.req, "wr_idx", {27'd0, wr_idx}, {27'd0, e.idx});
               check(e.req, "wr_data", wr_data, e.data);
               check(e.req, "len", {30'd0, len}, {30'd0, e.ln});
               check(e.req, "flags cy/ov/s/z",
                     {28'd0, flag_cy, flag_ov, flag_s, flag_z}, {28'd0, e.flags});
            end
         end else if (wr_en) begin
            check("R13", "wr_en without out_valid", 32'd1, 32'd0);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; hw0 = '0; hw1 = '0; hw2 = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
      check("R1", "wr_en", {31'd0, wr_en}, 32'd0);
      check("R1", "flags", {28'd0, flag_cy, flag_ov, flag_s, flag_z}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: long form, low halfword first
      issue(enc(5'd0, 6'b110001, 5'd1), 16'h0001, 16'h8000, 1, 5'd1, 32'h8000_0001, 2'd3, 4'b0000, "R5");
      // R2: register copy
      issue(enc(5'd2, 6'b000000, 5'd1), 16'h0, 16'h0, 1, 5'd2, 32'h8000_0001, 2'd1, 4'b0000, "R2");
      // R4: negative and positive 5-bit immediates
      issue(enc(5'd3, 6'b010000, 5'b11101), 16'h0, 16'h0, 1, 5'd3, 32'hFFFF_FFFD, 2'd1, 4'b0000, "R4");
      issue(enc(5'd13, 6'b010000, 5'b01111), 16'h0, 16'h0, 1, 5'd13, 32'h0000_000F, 2'd1, 4'b0000, "R4");
      idle();
      // R13: idle cycle in between must produce nothing
      @(negedge clk);
      check("R13", "idle out_valid", {31'd0, out_valid}, 32'd0);
      // R3 R9: NOT gives positive nonzero
      issue(enc(5'd4, 6'b000001, 5'd3), 16'h0, 16'h0, 1, 5'd4, 32'h0000_0002, 2'd1, 4'b0000, "R3 R9");
      // R3 R9: OR gives negative
      issue(enc(5'd4, 6'b001000, 5'd1), 16'h0, 16'h0, 1, 5'd4, 32'h8000_0003, 2'd1, 4'b0010, "R3 R9");
      // R5 R10: add sign-extended all-ones
      issue(enc(5'd5, 6'b110001, 5'd1), 16'hFFFF, 16'h0, 1, 5'd5, 32'h8000_0000, 2'd2, 4'b0010, "R5 R10");
      // R6 R10: high-half add
      issue(enc(5'd6, 6'b110010, 5'd1), 16'h1234, 16'h0, 1, 5'd6, 32'h9234_0001, 2'd2, 4'b0010, "R6 R10");
      // R7 R9: zero-extended OR immediate
      issue(enc(5'd7, 6'b110100, 5'd0), 16'h8001, 16'h0, 1, 5'd7, 32'h0000_8001, 2'd2, 4'b0000, "R7 R9");
      // R9: NOT of all ones gives zero
      issue(enc(5'd0, 6'b110001, 5'd8), 16'hFFFF, 16'hFFFF, 1, 5'd8, 32'hFFFF_FFFF, 2'd3, 4'b0000, "R5");
      issue(enc(5'd9, 6'b000001, 5'd8), 16'h0, 16'h0, 1, 5'd9, 32'h0000_0000, 2'd1, 4'b0001, "R9");
      // R8: write to register 0 discarded, register 0 reads zero
      issue(enc(5'd0, 6'b010000, 5'b00111), 16'h0, 16'h0, 0, 5'd0, 32'h0000_0007, 2'd1, 4'b0001, "R8");
      issue(enc(5'd10, 6'b000000, 5'd0), 16'h0, 16'h0, 1, 5'd10, 32'h0000_0000, 2'd1, 4'b0001, "R8");
      // R11: no-operation
      issue(16'h0000, 16'h0, 16'h0, 0, 5'd0, 32'h0000_0000, 2'd1, 4'b0001, "R11");
      // R12: unknown opcode
      issue(enc(5'd14, 6'b111111, 5'd1), 16'h5555, 16'h0, 0, 5'd14, 32'h0000_0000, 2'd1, 4'b0001, "R12");
      // R12: register 14 untouched
      issue(enc(5'd15, 6'b000000, 5'd14), 16'h0, 16'h0, 1, 5'd15, 32'h0000_0000, 2'd1, 4'b0001, "R12");
      // R13: dependent back-to-back pair
      issue(enc(5'd11, 6'b010000, 5'b00111), 16'h0, 16'h0, 1, 5'd11, 32'h0000_0007, 2'd1, 4'b0001, "R13");
      issue(enc(5'd12, 6'b000000, 5'd11), 16'h0, 16'h0, 1, 5'd12, 32'h0000_0007, 2'd1, 4'b0001, "R13");
      // R2: earlier results persist (copy of register 6)
      issue(enc(5'd16, 6'b000000, 5'd6), 16'h0, 16'h0, 1, 5'd16, 32'h9234_0001, 2'd1, 4'b0001, "R2");
      idle();
      repeat (3) @(negedge clk);
      check("R13", "all results seen", exp_q.size(), 32'd0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule